// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between the serial receive engine of a two-wire EEPROM and its storage array. Each data byte that arrives during a write is placed in a 64-slot page buffer, and the slot it fills is marked valid. The page base is fixed by the last address load. Only the low six address bits advance from byte to byte, so a long burst wraps back to the start of the page and overwrites earlier slots. When the engine signals the end of the transfer, the block checks whether the buffer holds anything worth writing. If it does, it raises busy and walks through the slots, issuing one array write per valid slot. It then holds busy for a fixed, parameterised programming time. While busy is high, every request is ignored.

The block also keeps the current address that a current-address read uses. After a written byte, this address is the next slot in the same page. After each read step, it advances through the whole array and wraps from the top address to zero. An address load sets it.

Top module: `eeprom_page_commit`

## Requirements
- R1: An accepted byte strobe (busy low, write protect low) stores `byte_i` at slot `off` of the loaded page and marks that slot valid. The slot offset then advances by one and the page part stays unchanged.
- R2: The slot offset wraps from 63 to 0 inside the same page. A later byte that lands on a slot already written replaces it, and only the last value is committed.
- R3: A commit strobe taken while at least one slot is valid and no protected byte was seen raises `busy_o` on the next cycle. A scan over offsets 0..63, one per clock, then issues exactly one `mem_we_o` pulse per valid slot, in ascending offset order, with `mem_addr_o` = {page, offset}. Invalid slots produce no write.
- R4: `busy_o` stays high for exactly 64 + `WR_CYCLES` clock cycles after such a commit and then falls. At that point all valid flags are cleared, so a following commit with no new bytes starts nothing.
- R5: While `busy_o` is high, byte, address-load, commit and read-advance strobes have no effect on the current address, the buffer or the cycle.
- R6: A commit with no valid slot leaves `busy_o` low and issues no array write.
- R7: A byte strobe with `wp_i` high is not stored. A later commit before the next address load then starts no cycle, issues no write and discards the collected bytes.
- R8: After reset `cur_vld_o` is 0. An accepted address load sets `cur_addr_o` to `addr_i` and `cur_vld_o` to 1.
- R9: After each accepted byte, `cur_addr_o` equals {page, (offset + 1) mod 64}.
- R10: An accepted read-advance strobe increments `cur_addr_o` by one modulo 2^`ADDR_W`. The increment crosses page boundaries, and the top address wraps to zero.
- R11: After reset `busy_o` and `mem_we_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_i | input | 1 | Write protect level, sampled with each byte strobe |
| addr_load_i | input | 1 | Load strobe for start address |
| addr_i | input | ADDR_W | Start address (page and offset) |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | DATA_W | Data byte |
| commit_i | input | 1 | Stop/commit strobe |
| rd_adv_i | input | 1 | Read-advance strobe for the current address |
| busy_o | output | 1 | Write cycle in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |
| cur_addr_o | output | ADDR_W | Current address for current-address reads |
| cur_vld_o | output | 1 | Current address has been set since reset |

## Verification
The assertions rely on the serial engine raising at most one of the four strobes in any cycle while the block is idle. They also assume that the page base does not move between the last byte and the commit. The bench respects both: it drives every strobe as a single-cycle pulse from its own task, one task at a time, and it only loads an address before a group of bytes. Strobes sent during busy are the one case where inputs arrive while the block is not idle. The bench sends them deliberately, and only as isolated pulses, to test that they are ignored.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_HOLD = 2'd2
  } wc_state_e;
endpackage

// File: rtl/pb_slot_buf.sv
module pb_slot_buf #(
  parameter int PAGE_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              wp_i,
  input  logic [PAGE_W-1:0] wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              any_vld_o,
  output logic              blocked_o
);
  localparam int SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] data_q [SLOTS];
  logic [SLOTS-1:0]  vld_q;
  logic              blocked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q     <= '0;
      blocked_q <= 1'b0;
      for (int i = 0; i < SLOTS; i++) data_q[i] <= '0;
    end else if (clr_i) begin
      vld_q     <= '0;
      blocked_q <= 1'b0;
    end else if (wr_i) begin
      if (wp_i) begin
        blocked_q <= 1'b1;
      end else begin
        data_q[wr_off_i] <= wr_data_i;
        vld_q[wr_off_i]  <= 1'b1;
      end
    end
  end

  assign rd_data_o = data_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];
  assign any_vld_o = |vld_q;
  assign blocked_o = blocked_q;

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !any_vld_o && !blocked_o);
  p_wp_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wp_i && !clr_i |=> blocked_o);
endmodule

// File: rtl/pb_addr_track.sv
module pb_addr_track #(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              byte_i,
  input  logic              rd_adv_i,
  output logic [ADDR_W-PAGE_W-1:0] page_o,
  output logic [PAGE_W-1:0] off_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              cur_vld_o
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic [HI_W-1:0]   page_q;
  logic [PAGE_W-1:0] off_q, off_nxt;
  logic [ADDR_W-1:0] cur_q;
  logic              cur_vld_q;

  assign off_nxt = off_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q    <= '0;
      off_q     <= '0;
      cur_q     <= '0;
      cur_vld_q <= 1'b0;
    end else if (load_i) begin
      page_q    <= load_addr_i[ADDR_W-1:PAGE_W];
      off_q     <= load_addr_i[PAGE_W-1:0];
      cur_q     <= load_addr_i;
      cur_vld_q <= 1'b1;
    end else if (byte_i) begin
      off_q <= off_nxt;
      cur_q <= {page_q, off_nxt};
    end else if (rd_adv_i) begin
      cur_q <= cur_q + 1'b1;
    end
  end

  assign page_o     = page_q;
  assign off_o      = off_q;
  assign cur_addr_o = cur_q;
  assign cur_vld_o  = cur_vld_q;

  p_page_fixed_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_i && !load_i |=> $stable(page_o));
  p_off_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_i && !load_i && (off_o == '1) |=> off_o == '0);
  p_rd_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_adv_i && !load_i && !byte_i && (cur_addr_o == '1) |=> cur_addr_o == '0);
endmodule

// File: rtl/pb_wr_cycle.sv
module pb_wr_cycle
  import pb_pkg::*;
#(
  parameter int PAGE_W    = 6,
  parameter int WR_CYCLES = 500000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  output logic              busy_o,
  output logic              scan_o,
  output logic [PAGE_W-1:0] idx_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_CYCLES - 1);

  wc_state_e         state_q;
  logic [PAGE_W-1:0] idx_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go_i) begin
          state_q <= ST_SCAN;
          idx_q   <= '0;
        end
        ST_SCAN: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == '1) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
          end
        end
        ST_HOLD: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign scan_o = (state_q == ST_SCAN);
  assign idx_o  = idx_q;
  assign done_o = (state_q == ST_HOLD) && (cnt_q == CNT_LAST);

  p_go_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i && !busy_o |=> scan_o && idx_o == '0);
  p_scan_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_o && (idx_o != '1) |=> scan_o && (idx_o == $past(idx_o) + 1'b1));
  p_done_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/eeprom_page_commit.sv
module eeprom_page_commit #(
  parameter int ADDR_W    = 14,
  parameter int PAGE_W    = 6,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 500000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              commit_i,
  input  logic              rd_adv_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              cur_vld_o
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic              busy, scan, done;
  logic [PAGE_W-1:0] idx;
  logic              load_acc, byte_acc, commit_acc, rd_acc, go, clr;
  logic [HI_W-1:0]   page;
  logic [PAGE_W-1:0] off;
  logic [DATA_W-1:0] rd_data;
  logic              rd_vld, any_vld, blocked;

  assign load_acc   = addr_load_i & ~busy;
  assign byte_acc   = byte_vld_i  & ~busy;
  assign commit_acc = commit_i    & ~busy;
  assign rd_acc     = rd_adv_i    & ~busy;
  assign go         = commit_acc & any_vld & ~blocked;
  assign clr        = load_acc | (commit_acc & ~go) | done;

  pb_addr_track #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_acc),
    .load_addr_i(addr_i),
    .byte_i     (byte_acc),
    .rd_adv_i   (rd_acc),
    .page_o     (page),
    .off_o      (off),
    .cur_addr_o (cur_addr_o),
    .cur_vld_o  (cur_vld_o)
  );

  pb_slot_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (byte_acc),
    .wp_i     (wp_i),
    .wr_off_i (off),
    .wr_data_i(byte_i),
    .clr_i    (clr),
    .rd_idx_i (idx),
    .rd_data_o(rd_data),
    .rd_vld_o (rd_vld),
    .any_vld_o(any_vld),
    .blocked_o(blocked)
  );

  pb_wr_cycle #(.PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_cyc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (go),
    .busy_o(busy),
    .scan_o(scan),
    .idx_o (idx),
    .done_o(done)
  );

  assign busy_o      = busy;
  assign mem_we_o    = scan & rd_vld;
  assign mem_addr_o  = {page, idx};
  assign mem_wdata_o = rd_data;

  p_we_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  p_ignore_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (byte_vld_i || addr_load_i || rd_adv_i) |=> $stable(cur_addr_o));
  p_nogo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !busy_o && !any_vld |=> !busy_o);
  p_one_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> $onehot0({addr_load_i, byte_vld_i, commit_i, rd_adv_i}));
  p_page_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(page));
endmodule

// File: tb/sim_eeprom_page_commit.sv
module sim_eeprom_page_commit;
  localparam int AW = 14;
  localparam int WC = 10;
  localparam int BUSY_LEN = 64 + WC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp = 1'b0, addr_load = 1'b0, byte_vld = 1'b0, commit = 1'b0, rd_adv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] bdat = '0;
  logic busy, mem_we, cur_vld;
  logic [AW-1:0] mem_addr, cur_addr;
  logic [7:0] mem_wdata;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int wr_n = 0;
  logic [AW-1:0] cap_a [256];
  logic [7:0]    cap_d [256];

  always #5 clk = ~clk;

  eeprom_page_commit #(.ADDR_W(AW), .PAGE_W(6), .DATA_W(8), .WR_CYCLES(WC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wp_i(wp), .addr_load_i(addr_load), .addr_i(addr),
    .byte_vld_i(byte_vld), .byte_i(bdat), .commit_i(commit), .rd_adv_i(rd_adv),
    .busy_o(busy), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .cur_addr_o(cur_addr), .cur_vld_o(cur_vld)
  );

  always @(negedge clk) begin
    if (mem_we) begin
      cap_a[wr_n[7:0]] <= mem_addr;
      cap_d[wr_n[7:0]] <= mem_wdata;
      wr_n <= wr_n + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [AW-1:0] a);
    @(negedge clk); addr_load = 1'b1; addr = a;
    @(negedge clk); addr_load = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] d, input logic w);
    @(negedge clk); byte_vld = 1'b1; bdat = d; wp = w;
    @(negedge clk); byte_vld = 1'b0; wp = 1'b0;
  endtask

  task automatic do_commit();
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
  endtask

  task automatic do_rdadv();
    @(negedge clk); rd_adv = 1'b1;
    @(negedge clk); rd_adv = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      @(negedge clk);
      n = n + 1;
    end
  endtask

  initial begin
    int n, base;
    logic [7:0] exp_d [64];
    logic [AW-1:0] a;
    logic [AW-1:0] hold;

    repeat (3) @(negedge clk);
    // R11 / R8 reset state
    chk(busy == 1'b0, "R11 busy after reset", busy, 0);
    chk(mem_we == 1'b0, "R11 we after reset", mem_we, 0);
    chk(cur_vld == 1'b0, "R8 cur_vld after reset", cur_vld, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 empty commit
    do_commit();
    chk(busy == 1'b0, "R6 empty commit busy", busy, 0);

    // R8 load
    do_load(14'h0123);
    chk(cur_addr == 14'h0123 && cur_vld, "R8 load sets cur", cur_addr, 14'h0123);

    // R1 R9 three bytes
    for (int i = 0; i < 3; i++) begin
      do_byte(8'hA0 + 8'(i), 1'b0);
      chk(cur_addr == 14'h0124 + 14'(i), "R9 cur after byte", cur_addr, 14'h0124 + i);
    end
    base = wr_n;
    do_commit();
    chk(busy == 1'b1, "R3 busy after commit", busy, 1);
    wait_idle(n);
    chk(n == BUSY_LEN, "R4 busy length", n, BUSY_LEN);
    chk(wr_n - base == 3, "R3 write count", wr_n - base, 3);
    for (int i = 0; i < 3; i++) begin
      chk(cap_a[8'(base + i)] == 14'h0123 + 14'(i), "R3 write addr", cap_a[8'(base + i)], 14'h0123 + i);
      chk(cap_d[8'(base + i)] == 8'hA0 + 8'(i), "R1 write data", cap_d[8'(base + i)], 8'hA0 + i);
    end
    base = wr_n;
    do_commit();
    chk(busy == 1'b0 && wr_n == base, "R4 flags cleared", busy, 0);

    // R2 wrap: page 7, start offset 60, 70 bytes
    do_load(14'(7 * 64 + 60));
    for (int i = 0; i < 70; i++) begin
      do_byte(8'(i * 3 + 1), 1'b0);
      exp_d[(60 + i) % 64] = 8'(i * 3 + 1);
    end
    chk(cur_addr == 14'(7 * 64 + 2), "R9 cur after wrap", cur_addr, 7 * 64 + 2);
    base = wr_n;
    do_commit();
    wait_idle(n);
    chk(wr_n - base == 64, "R2 full page count", wr_n - base, 64);
    for (int k = 0; k < 64; k++) begin
      chk(cap_a[8'(base + k)] == 14'(7 * 64 + k), "R2 wrap addr", cap_a[8'(base + k)], 7 * 64 + k);
      chk(cap_d[8'(base + k)] == exp_d[k], "R2 overwrite data", cap_d[8'(base + k)], exp_d[k]);
    end

    // R5 inputs ignored while busy
    do_load(14'h0040);
    do_byte(8'h11, 1'b0);
    do_commit();
    hold = cur_addr;
    do_load(14'h3000);
    do_byte(8'h22, 1'b0);
    do_rdadv();
    do_commit();
    chk(busy == 1'b1, "R5 still busy", busy, 1);
    chk(cur_addr == hold, "R5 cur unchanged", cur_addr, hold);
    wait_idle(n);
    chk(n + 8 == BUSY_LEN, "R5 cycle not restarted", n + 8, BUSY_LEN);
    base = wr_n;
    do_commit();
    chk(busy == 1'b0 && wr_n == base, "R5 byte ignored", wr_n - base, 0);

    // R7 write protect
    do_load(14'h0200);
    do_byte(8'h55, 1'b0);
    do_byte(8'h66, 1'b1);
    base = wr_n;
    do_commit();
    chk(busy == 1'b0, "R7 protected commit busy", busy, 0);
    repeat (3) @(negedge clk);
    chk(wr_n == base, "R7 no write", wr_n - base, 0);
    do_commit();
    chk(busy == 1'b0, "R7 bytes discarded", busy, 0);

    // R10 read advance
    do_load(14'h3FFE);
    do_rdadv();
    chk(cur_addr == 14'h3FFF, "R10 step", cur_addr, 14'h3FFF);
    do_rdadv();
    chk(cur_addr == 14'h0000, "R10 top wrap", cur_addr, 0);
    do_load(14'h007F);
    do_rdadv();
    chk(cur_addr == 14'h0080, "R10 page cross", cur_addr, 14'h0080);

    // R1 R3 sweep: one byte at every offset
    for (int o = 0; o < 64; o++) begin
      a = {8'(o ^ 5), 6'(o)};
      do_load(a);
      do_byte(8'(o + 8'h40), 1'b0);
      base = wr_n;
      do_commit();
      wait_idle(n);
      chk(n == BUSY_LEN && wr_n - base == 1, "R3 sweep single write", wr_n - base, 1);
      chk(cap_a[8'(base)] == a && cap_d[8'(base)] == 8'(o + 8'h40), "R1 sweep slot", cap_a[8'(base)], a);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule